// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Break Tracking

This block turns an oversampled serial line into whole characters. It finds a start bit, rejects short low glitches, samples each data bit near its centre and checks an optional parity bit and the stop bit. Each finished character moves into a single holding register. A status word beside that register reports buffer-full, parity-error, frame-error, break, overrun and character-in-progress. The surrounding logic reads the status through a one-cycle strobe, and that strobe also clears flags. Three one-cycle interrupt pulses report new data, receive errors, and the end of a break.

A break is its own class of word, separate from a frame error. A word with all data bits zero and a low stop bit is a break. The break flag stays set until two things have both happened: the line has been seen high again, and the status has been read at least once since the break was stored. The two may happen in either order. The flag falls the moment the second one arrives, and the end-of-break pulse fires at the same moment.

Top module: `serial_rx_brk`

## Requirements
- R1: After reset every status flag, every interrupt output and `rx_data` read zero.
- R2: A start bit is accepted only if the line is still low 8 sample ticks after the low was first seen. A shorter low pulse is ignored: no character starts and nothing is stored.
- R3: The line idles high. Data arrives least significant bit first. `cfg_len` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits, and the unused upper bits of `rx_data` read zero. `cfg_par` 1 selects even parity, 2 selects odd parity, and 0 or 3 selects no parity bit. One stop bit follows.
- R4: `st_full` sets when a character is stored, and `irq_data` pulses for every stored character that is not a break. `st_full` clears on `stat_rd`.
- R5: Every stored character rewrites `st_perr`: it is 1 if the parity bit was wrong and 0 otherwise.
- R6: Every stored character rewrites `st_ferr`: it is 1 when the stop bit was sampled low and the data bits were not all zero, and 0 otherwise.
- R7: A stored character with all data bits zero and a low stop bit sets `st_brk` and pulses `irq_err`. It leaves `st_ferr` and `st_perr` at zero.
- R8: `st_brk` clears only once the line has been seen high and a `stat_rd` has occurred since the break was stored, in either order. `irq_eob` pulses for one cycle in the cycle the flag falls.
- R9: `st_cip` rises when a start bit is accepted and falls when the stop bit is sampled.
- R10: A character that completes while `st_full` is set, and not read in that cycle, is discarded. `st_ovr` sets, `irq_err` pulses, and `rx_data` stays unchanged. `stat_rd` clears `st_ovr`.
- R11: `irq_err` pulses when a stored character has a parity error, a frame error or a break.
- R12: After a character whose stop bit was low, no new character starts until the line has been seen high.
- R13: A sample tick occurs every `baud_div`+1 clocks, so one bit lasts 16·(`baud_div`+1) clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| baud_div | input | 8 | Tick divisor: one sample tick every baud_div+1 clocks |
| rxd | input | 1 | Serial line, asynchronous |
| cfg_len | input | 2 | Data length code (5 + code bits) |
| cfg_par | input | 2 | Parity mode: 1 even, 2 odd, 0/3 none |
| stat_rd | input | 1 | Status read strobe |
| rx_data | output | 8 | Receive holding register |
| st_full | output | 1 | Buffer-full flag |
| st_perr | output | 1 | Parity-error flag |
| st_ferr | output | 1 | Frame-error flag |
| st_brk | output | 1 | Break flag |
| st_cip | output | 1 | Character-in-progress flag |
| st_ovr | output | 1 | Overrun flag |
| irq_data | output | 1 | Receive-data interrupt pulse |
| irq_err | output | 1 | Receive-error interrupt pulse |
| irq_eob | output | 1 | End-of-break interrupt pulse |

## Verification
The receiver gets clean characters at several lengths and parity modes. These show whether bit order, length masking and the parity sense are right. Words with a low stop bit are sent twice, once with non-zero data and once with all-zero data, which separates a frame error from a break. The break is then ended twice: read before the line rises, and line rising before the read. This shows that neither event alone clears the flag. A short low glitch, two back-to-back words with no read between them, and a run with a larger divisor cover start rejection, overrun and tick timing.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

  localparam int RXB_DMAX = 8;

  typedef enum logic [1:0] {
    PAR_OFF  = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2,
    PAR_OFF2 = 2'd3
  } par_mode_e;

  typedef enum logic [1:0] {
    FS_IDLE,
    FS_START,
    FS_BITS,
    FS_WAITHI
  } fstate_e;

  // number of data bits selected by a length code
  function automatic int unsigned len_of(input logic [1:0] code);
    return 32'd5 + 32'(code);
  endfunction

  function automatic logic par_on(input logic [1:0] m);
    return (m == PAR_EVEN) || (m == PAR_ODD);
  endfunction

  // 1 when the received parity bit does not match the mode
  function automatic logic par_bad(input logic [RXB_DMAX-1:0] d,
                                   input logic pbit,
                                   input logic [1:0] m);
    logic ones;
    ones = (^d) ^ pbit;
    if (m == PAR_EVEN) return ones;
    if (m == PAR_ODD)  return ~ones;
    return 1'b0;
  endfunction

endpackage

// File: rtl/rxb_baud.sv
module rxb_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  assign tick = (cnt >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/rxb_frame.sv
module rxb_frame
  import rxb_pkg::*;
#(
  parameter int OS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                rxd_raw,
  input  logic [1:0]          cfg_len,
  input  logic [1:0]          cfg_par,
  output logic                done,
  output logic [RXB_DMAX-1:0] word_data,
  output logic                word_pbad,
  output logic                word_stop,
  output logic                cip,
  output logic                line_hi,
  output logic                start_ok,
  output logic                glitch
);

  localparam int PH_W = $clog2(OS);
  localparam int BC_W = $clog2(RXB_DMAX + 3);
  localparam int IX_W = $clog2(RXB_DMAX);
  localparam logic [PH_W-1:0] PH_MID  = PH_W'(OS / 2 - 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OS - 1);

  logic                sync1, sync2, rxd;
  fstate_e             state;
  logic [PH_W-1:0]     ph;
  logic [BC_W-1:0]     bc;
  logic [BC_W-1:0]     nlen;
  logic [1:0]          len_q;
  logic [1:0]          par_q;
  logic [RXB_DMAX-1:0] data;
  logic                pbit;

  assign rxd  = sync2;
  assign nlen = BC_W'(len_of(len_q));

  assign start_ok = tick && (state == FS_START) && (ph == PH_MID) && !rxd;
  assign glitch   = tick && (state == FS_START) && (ph == PH_MID) && rxd;
  assign line_hi  = tick && (state == FS_WAITHI) && rxd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b1;
      sync2 <= 1'b1;
    end else begin
      sync1 <= rxd_raw;
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= FS_IDLE;
      ph        <= '0;
      bc        <= '0;
      len_q     <= '0;
      par_q     <= '0;
      data      <= '0;
      pbit      <= 1'b0;
      cip       <= 1'b0;
      done      <= 1'b0;
      word_data <= '0;
      word_pbad <= 1'b0;
      word_stop <= 1'b1;
    end else begin
      done <= 1'b0;
      if (tick) begin
        case (state)
          FS_IDLE: begin
            if (!rxd) begin
              state <= FS_START;
              ph    <= '0;
            end
          end
          FS_START: begin
            if (ph == PH_MID) begin
              ph <= '0;
              if (!rxd) begin
                state <= FS_BITS;
                bc    <= '0;
                cip   <= 1'b1;
                len_q <= cfg_len;
                par_q <= cfg_par;
                data  <= '0;
                pbit  <= 1'b0;
              end else begin
                state <= FS_IDLE;
              end
            end else begin
              ph <= ph + 1'b1;
            end
          end
          FS_BITS: begin
            if (ph == PH_LAST) begin
              ph <= '0;
              bc <= bc + 1'b1;
              if (bc < nlen) begin
                data[bc[IX_W-1:0]] <= rxd;
              end else if (par_on(par_q) && (bc == nlen)) begin
                pbit <= rxd;
              end else begin
                done      <= 1'b1;
                word_data <= data;
                word_pbad <= par_bad(data, pbit, par_q);
                word_stop <= rxd;
                cip       <= 1'b0;
                state     <= rxd ? FS_IDLE : FS_WAITHI;
              end
            end else begin
              ph <= ph + 1'b1;
            end
          end
          default: begin
            if (rxd) state <= FS_IDLE;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/rxb_status.sv
module rxb_status
  import rxb_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                done,
  input  logic [RXB_DMAX-1:0] word_data,
  input  logic                word_pbad,
  input  logic                word_stop,
  input  logic                line_hi,
  input  logic                stat_rd,
  output logic [RXB_DMAX-1:0] rx_data,
  output logic                st_full,
  output logic                st_perr,
  output logic                st_ferr,
  output logic                st_brk,
  output logic                st_ovr,
  output logic                irq_data,
  output logic                irq_err,
  output logic                irq_eob,
  output logic                buf_load,
  output logic                word_brk
);

  logic full_eff, ovr_hit, brk_ack, brk_end, brk_clear, word_ferr;

  assign word_brk  = done && !word_stop && (word_data == '0);
  assign word_ferr = !word_stop && (word_data != '0);
  assign full_eff  = st_full && !stat_rd;
  assign buf_load  = done && !full_eff;
  assign ovr_hit   = done && full_eff;
  assign brk_clear = st_brk && (brk_ack || stat_rd) && (brk_end || line_hi)
                     && !(buf_load && word_brk);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data  <= '0;
      st_full  <= 1'b0;
      st_perr  <= 1'b0;
      st_ferr  <= 1'b0;
      st_ovr   <= 1'b0;
      irq_data <= 1'b0;
      irq_err  <= 1'b0;
    end else begin
      irq_data <= 1'b0;
      irq_err  <= 1'b0;
      if (stat_rd) begin
        st_full <= 1'b0;
        st_ovr  <= 1'b0;
      end
      if (buf_load) begin
        rx_data  <= word_data;
        st_full  <= 1'b1;
        st_perr  <= word_pbad && !word_brk;
        st_ferr  <= word_ferr;
        irq_data <= !word_brk;
        irq_err  <= word_brk || word_ferr || word_pbad;
      end
      if (ovr_hit) begin
        st_ovr  <= 1'b1;
        irq_err <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_brk  <= 1'b0;
      brk_ack <= 1'b0;
      brk_end <= 1'b0;
      irq_eob <= 1'b0;
    end else begin
      irq_eob <= 1'b0;
      if (buf_load && word_brk) begin
        st_brk  <= 1'b1;
        brk_ack <= 1'b0;
        brk_end <= line_hi;
      end else if (brk_clear) begin
        st_brk  <= 1'b0;
        brk_ack <= 1'b0;
        brk_end <= 1'b0;
        irq_eob <= 1'b1;
      end else if (st_brk) begin
        if (stat_rd) brk_ack <= 1'b1;
        if (line_hi) brk_end <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/serial_rx_brk.sv
module serial_rx_brk
  import rxb_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int OS    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DIV_W-1:0]    baud_div,
  input  logic                rxd,
  input  logic [1:0]          cfg_len,
  input  logic [1:0]          cfg_par,
  input  logic                stat_rd,
  output logic [RXB_DMAX-1:0] rx_data,
  output logic                st_full,
  output logic                st_perr,
  output logic                st_ferr,
  output logic                st_brk,
  output logic                st_cip,
  output logic                st_ovr,
  output logic                irq_data,
  output logic                irq_err,
  output logic                irq_eob
);

  logic                tick;
  logic                done;
  logic [RXB_DMAX-1:0] word_data;
  logic                word_pbad;
  logic                word_stop;
  logic                line_hi;
  logic                start_ok;
  logic                glitch;
  logic                buf_load;
  logic                word_brk;

  rxb_baud #(.DIV_W(DIV_W)) u_baud (
    .clk  (clk),
    .rst_n(rst_n),
    .div  (baud_div),
    .tick (tick)
  );

  rxb_frame #(.OS(OS)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .rxd_raw  (rxd),
    .cfg_len  (cfg_len),
    .cfg_par  (cfg_par),
    .done     (done),
    .word_data(word_data),
    .word_pbad(word_pbad),
    .word_stop(word_stop),
    .cip      (st_cip),
    .line_hi  (line_hi),
    .start_ok (start_ok),
    .glitch   (glitch)
  );

  rxb_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .done     (done),
    .word_data(word_data),
    .word_pbad(word_pbad),
    .word_stop(word_stop),
    .line_hi  (line_hi),
    .stat_rd  (stat_rd),
    .rx_data  (rx_data),
    .st_full  (st_full),
    .st_perr  (st_perr),
    .st_ferr  (st_ferr),
    .st_brk   (st_brk),
    .st_ovr   (st_ovr),
    .irq_data (irq_data),
    .irq_err  (irq_err),
    .irq_eob  (irq_eob),
    .buf_load (buf_load),
    .word_brk (word_brk)
  );

endmodule

// File: rtl/serial_rx_brk_chk.sv
module serial_rx_brk_chk
  import rxb_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                stat_rd,
  input logic                done,
  input logic                buf_load,
  input logic                word_brk,
  input logic                start_ok,
  input logic                glitch,
  input logic [RXB_DMAX-1:0] rx_data,
  input logic                st_full,
  input logic                st_ferr,
  input logic                st_brk,
  input logic                st_cip,
  input logic                st_ovr,
  input logic                irq_err,
  input logic                irq_eob
);

  assert_load_sets_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    buf_load |=> st_full);

  assert_read_clears_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !done) |=> !st_full);

  assert_brk_not_ferr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_load && word_brk) |=> (st_brk && !st_ferr && irq_err));

  assert_eob_at_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st_brk) |-> irq_eob);

  assert_eob_only_at_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_eob |-> (!st_brk && $past(st_brk)));

  assert_cip_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> st_cip);

  assert_cip_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !st_cip);

  assert_glitch_dropped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    glitch |=> !st_cip);

  assert_overrun_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && st_full && !stat_rd) |=> (st_ovr && irq_err && $stable(rx_data)));

endmodule

bind serial_rx_brk serial_rx_brk_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .stat_rd (stat_rd),
  .done    (done),
  .buf_load(buf_load),
  .word_brk(word_brk),
  .start_ok(start_ok),
  .glitch  (glitch),
  .rx_data (rx_data),
  .st_full (st_full),
  .st_ferr (st_ferr),
  .st_brk  (st_brk),
  .st_cip  (st_cip),
  .st_ovr  (st_ovr),
  .irq_err (irq_err),
  .irq_eob (irq_eob)
);

// File: tb/tb_serial_rx_brk.sv
module tb_serial_rx_brk;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] baud_div = 8'd0;
  logic       rxd = 1'b1;
  logic [1:0] cfg_len = 2'd3;
  logic [1:0] cfg_par = 2'd0;
  logic       stat_rd = 1'b0;
  logic [7:0] rx_data;
  logic       st_full, st_perr, st_ferr, st_brk, st_cip, st_ovr;
  logic       irq_data, irq_err, irq_eob;

  int n_chk = 0;
  int n_err = 0;
  int cnt_data = 0;
  int cnt_err = 0;
  int cnt_eob = 0;
  int cur_div = 0;

  always #4 clk = ~clk;

  serial_rx_brk dut (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .rxd(rxd),
    .cfg_len(cfg_len), .cfg_par(cfg_par), .stat_rd(stat_rd),
    .rx_data(rx_data), .st_full(st_full), .st_perr(st_perr),
    .st_ferr(st_ferr), .st_brk(st_brk), .st_cip(st_cip), .st_ovr(st_ovr),
    .irq_data(irq_data), .irq_err(irq_err), .irq_eob(irq_eob)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (irq_data) cnt_data++;
      if (irq_err)  cnt_err++;
      if (irq_eob)  cnt_eob++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bit_time(input logic v);
    rxd = v;
    repeat (16 * (cur_div + 1)) @(negedge clk);
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read();
    @(negedge clk);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    wait_clk(2);
  endtask

  // pm: 0 none, 1 even, 2 odd
  task automatic send(input logic [7:0] d, input int len, input int pm,
                      input logic stop, input bit flip, input bit hold_low,
                      input bit probe);
    logic [7:0] m;
    logic p;
    cfg_len = 2'(len - 5);
    cfg_par = 2'(pm);
    m = d & (8'hFF >> (8 - len));
    @(negedge clk);
    bit_time(1'b0);
    for (int i = 0; i < len; i++) begin
      bit_time(d[i]);
      if (probe && i == 1) check("R9 cip mid-frame", int'(st_cip), 1);
    end
    if (pm == 1 || pm == 2) begin
      p = (^m) ^ (pm == 2) ^ flip;
      bit_time(p);
    end
    bit_time(stop);
    rxd = hold_low ? 1'b0 : 1'b1;
    wait_clk(4);
  endtask

  task automatic t_reset();
    check("R1 rx_data", int'(rx_data), 0);
    check("R1 full", int'(st_full), 0);
    check("R1 perr", int'(st_perr), 0);
    check("R1 ferr", int'(st_ferr), 0);
    check("R1 brk", int'(st_brk), 0);
    check("R1 cip", int'(st_cip), 0);
    check("R1 ovr", int'(st_ovr), 0);
    check("R1 irqs", int'({irq_data, irq_err, irq_eob}), 0);
  endtask

  task automatic t_basic();
    int c0;
    c0 = cnt_data;
    send(8'hA5, 8, 0, 1'b1, 0, 0, 0);
    check("R4 full set", int'(st_full), 1);
    check("R3 data 8N1", int'(rx_data), 8'hA5);
    check("R4 irq_data", cnt_data, c0 + 1);
    check("R6 ferr clear", int'(st_ferr), 0);
    do_read();
    check("R4 full cleared", int'(st_full), 0);
  endtask

  task automatic t_len();
    send(8'hF3, 5, 0, 1'b1, 0, 0, 0);
    check("R3 5-bit data", int'(rx_data), 8'h13);
    do_read();
    send(8'hED, 6, 0, 1'b1, 0, 0, 0);
    check("R3 6-bit data", int'(rx_data), 8'h2D);
    do_read();
  endtask

  task automatic t_parity();
    int e0;
    send(8'h35, 7, 1, 1'b1, 0, 0, 0);
    check("R5 even good", int'(st_perr), 0);
    check("R3 7-bit data", int'(rx_data), 8'h35);
    do_read();
    e0 = cnt_err;
    send(8'h35, 7, 1, 1'b1, 1, 0, 0);
    check("R5 even bad", int'(st_perr), 1);
    check("R11 irq_err parity", cnt_err, e0 + 1);
    do_read();
    send(8'h35, 7, 2, 1'b1, 0, 0, 0);
    check("R5 odd good clears", int'(st_perr), 0);
    do_read();
    send(8'h34, 8, 2, 1'b1, 1, 0, 0);
    check("R5 odd bad", int'(st_perr), 1);
    do_read();
  endtask

  task automatic t_frame();
    int c0, e0;
    c0 = cnt_data;
    e0 = cnt_err;
    send(8'h3C, 8, 0, 1'b0, 0, 1, 0);
    check("R6 ferr set", int'(st_ferr), 1);
    check("R7 not break", int'(st_brk), 0);
    check("R11 irq_err frame", cnt_err, e0 + 1);
    wait_clk(80);
    check("R12 no restart while low cip", int'(st_cip), 0);
    rxd = 1'b1;
    wait_clk(40);
    check("R12 no extra word", cnt_data, c0 + 1);
    do_read();
    send(8'h3C, 8, 0, 1'b1, 0, 0, 0);
    check("R6 ferr cleared by good word", int'(st_ferr), 0);
    do_read();
  endtask

  task automatic t_break_read_first();
    int e0, b0;
    e0 = cnt_err;
    b0 = cnt_eob;
    send(8'h00, 8, 0, 1'b0, 0, 1, 0);
    check("R7 brk set", int'(st_brk), 1);
    check("R7 ferr clear", int'(st_ferr), 0);
    check("R7 perr clear", int'(st_perr), 0);
    check("R7 irq_err", cnt_err, e0 + 1);
    do_read();
    wait_clk(30);
    check("R8 brk held while low", int'(st_brk), 1);
    check("R8 no eob yet", cnt_eob, b0);
    rxd = 1'b1;
    wait_clk(10);
    check("R8 brk cleared", int'(st_brk), 0);
    check("R8 eob pulse", cnt_eob, b0 + 1);
  endtask

  task automatic t_break_high_first();
    int b0;
    b0 = cnt_eob;
    send(8'h00, 6, 1, 1'b0, 0, 1, 0);
    check("R7 brk set even parity", int'(st_brk), 1);
    wait_clk(20);
    rxd = 1'b1;
    wait_clk(30);
    check("R8 brk held without read", int'(st_brk), 1);
    check("R8 no eob before read", cnt_eob, b0);
    do_read();
    check("R8 brk cleared by read", int'(st_brk), 0);
    check("R8 eob after read", cnt_eob, b0 + 1);
  endtask

  task automatic t_glitch();
    int c0;
    c0 = cnt_data;
    @(negedge clk);
    rxd = 1'b0;
    wait_clk(4);
    rxd = 1'b1;
    wait_clk(6);
    check("R2 glitch no cip", int'(st_cip), 0);
    wait_clk(200);
    check("R2 glitch no load", int'(st_full), 0);
    check("R2 glitch no irq", cnt_data, c0);
  endtask

  task automatic t_cip();
    send(8'h6B, 8, 0, 1'b1, 0, 0, 1);
    check("R9 cip low after stop", int'(st_cip), 0);
    do_read();
  endtask

  task automatic t_overrun();
    int e0;
    send(8'h11, 8, 0, 1'b1, 0, 0, 0);
    e0 = cnt_err;
    send(8'h22, 8, 0, 1'b1, 0, 0, 0);
    check("R10 ovr set", int'(st_ovr), 1);
    check("R10 data kept", int'(rx_data), 8'h11);
    check("R10 irq_err", cnt_err, e0 + 1);
    do_read();
    check("R10 ovr cleared", int'(st_ovr), 0);
    check("R4 full cleared after ovr", int'(st_full), 0);
  endtask

  task automatic t_div();
    cur_div = 2;
    baud_div = 8'd2;
    wait_clk(4);
    send(8'h5A, 8, 0, 1'b1, 0, 0, 0);
    check("R13 data at slower tick", int'(rx_data), 8'h5A);
    do_read();
    cur_div = 0;
    baud_div = 8'd0;
    wait_clk(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    wait_clk(5);
    t_reset();
    rst_n = 1'b1;
    wait_clk(5);
    t_basic();
    t_len();
    t_parity();
    t_frame();
    t_break_read_first();
    t_break_high_first();
    t_glitch();
    t_cip();
    t_overrun();
    t_div();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule